// File: doc/BRIEF.md
# Byte-Streaming Memory Bridge

This block links a narrow host bus of eleven signals (eight data lines, a phase select and two active-low strobes) to a wide asynchronous static memory with a full parallel address bus. The host does not present an address on each access. Instead it writes a start address as three bytes into an internal 24-bit counter. After that it streams bytes in or out with single strobes. The counter moves by one after every completed data access, so the host never resends the address during sequential transfers. The top bit of the loaded value selects whether the counter counts up or down.

On the memory side the bridge runs timed cycles with a configurable number of wait states. A write takes one setup cycle with chip-enable low, then write-enable low for `WAIT_CYC` cycles, then one hold cycle. A read keeps chip-enable and output-enable low for `WAIT_CYC` cycles and captures the byte at the end of the pulse. The host data pins are split into an input, an output and an output-enable, so the pad ring can form the bidirectional bus.

The host strobes set the pace of the stream, and there is no ready signal. Back-pressure is a timing contract. A read strobe must stay low for at least `WAIT_CYC`+2 clock cycles. After a data write strobe is released, no new strobe may start for `WAIT_CYC`+3 cycles. All host inputs are synchronous to `clk`.

Top module: `byte_stream_bridge`

## Requirements
- R1: While reset is held and directly after it, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are high, `hst_data_oe` is low, and `mem_addr` is zero.
- R2: Each write strobe that completes with `hst_phase`=1 shifts the 24-bit counter left by eight bits and places `hst_data_in` in the low byte. After three such writes (most significant byte first), bits 22:0 of the loaded value appear on `mem_addr`.
- R3: A write strobe that completes with `hst_phase`=0 produces one memory write. `mem_ce_n` is low for a setup cycle, then `mem_we_n` is low for exactly `WAIT_CYC` cycles, then `mem_ce_n` stays low for a hold cycle. Throughout, `mem_addr` and `mem_wdata` (the strobed byte) are stable.
- R4: A read strobe that starts with `hst_phase`=0 produces one memory read, with `mem_ce_n` and `mem_oe_n` low for `WAIT_CYC` cycles. The captured byte appears on `hst_data_out` while the strobe is still held.
- R5: When bit 23 of the loaded value is 0, each completed data-phase read or write raises `mem_addr` by one.
- R6: When bit 23 of the loaded value is 1, each completed data-phase read or write lowers `mem_addr` by one.
- R7: The address wraps modulo 2^23. Counting up from 0x7FFFFF gives 0, and counting down from 0 gives 0x7FFFFF.
- R8: `hst_data_oe` is high only while `hst_rd_n` is low and `hst_phase` is 0.
- R9: A read strobe with `hst_phase`=1 starts no memory cycle and leaves the counter unchanged.
- R10: `mem_we_n` is never low together with `mem_oe_n`, and neither of them is ever low while `mem_ce_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_phase | input | 1 | 1 = address phase, 0 = data phase |
| hst_wr_n | input | 1 | Host write strobe, active low, completes on release |
| hst_rd_n | input | 1 | Host read strobe, active low |
| hst_data_in | input | 8 | Byte from host data pins |
| hst_data_out | output | 8 | Byte to host data pins |
| hst_data_oe | output | 1 | Drive enable for host data pins |
| mem_addr | output | 23 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |

## Verification
The assertions assume the host follows the pacing contract. Only one strobe is active at a time, `hst_phase` stays fixed across a strobe, and no new strobe starts while a memory cycle is still running. If a strobe arrived during a cycle, the address-stability and wait-count properties could fail for reasons outside the bridge. The bench's driver tasks hold every strobe for a fixed number of cycles derived from `WAIT_CYC` and insert the required idle gap afterwards, so the stimulus always stays within these assumptions.

// File: rtl/bsb_pkg.sv
package bsb_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WSET,
    SQ_WPUL,
    SQ_WHLD,
    SQ_RPUL
  } seq_state_e;
endpackage

// File: rtl/bsb_host_decode.sv
module bsb_host_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic phase,
  input  logic wr_n,
  input  logic rd_n,
  output logic addr_load,
  output logic data_wr,
  output logic rd_start,
  output logic rd_done
);
  logic wr_q, rd_q;
  logic wr_rise, rd_fall, rd_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      wr_q <= wr_n;
      rd_q <= rd_n;
    end
  end

  assign wr_rise   = !wr_q && wr_n;
  assign rd_fall   = rd_q && !rd_n;
  assign rd_rise   = !rd_q && rd_n;
  assign addr_load = wr_rise && phase;
  assign data_wr   = wr_rise && !phase;
  assign rd_start  = rd_fall && !phase;
  assign rd_done   = rd_rise && !phase;
endmodule

// File: rtl/bsb_addr_counter.sv
module bsb_addr_counter #(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              dir
);
  localparam int CNT_W = ADDR_W + 1;

  logic [CNT_W-1:0] cnt_q;

  assign addr = cnt_q[ADDR_W-1:0];
  assign dir  = cnt_q[CNT_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= {cnt_q[CNT_W-DATA_W-1:0], load_byte};
    end else if (step) begin
      cnt_q[ADDR_W-1:0] <= dir ? (addr - ADDR_W'(1)) : (addr + ADDR_W'(1));
    end
  end

  // R5 / R7: upward steps wrap modulo the address range
  assert_step_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !dir) |=> (addr == ADDR_W'($past(addr) + ADDR_W'(1))));

  // R6 / R7: downward steps wrap modulo the address range
  assert_step_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && dir) |=> (addr == ADDR_W'($past(addr) - ADDR_W'(1))));
endmodule

// File: rtl/bsb_mem_seq.sv
module bsb_mem_seq
  import bsb_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int WAIT_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              rd_go,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              wr_done
);
  localparam int CW = $clog2(WAIT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

  seq_state_e state_q;
  logic [CW-1:0] wcnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      wcnt_q  <= '0;
      wdata   <= '0;
      rdata   <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          wcnt_q <= '0;
          if (wr_go) begin
            state_q <= SQ_WSET;
            wdata   <= wr_byte;
          end else if (rd_go) begin
            state_q <= SQ_RPUL;
          end
        end
        SQ_WSET: state_q <= SQ_WPUL;
        SQ_WPUL: begin
          if (wcnt_q == LAST) state_q <= SQ_WHLD;
          else                wcnt_q  <= wcnt_q + CW'(1);
        end
        SQ_WHLD: state_q <= SQ_IDLE;
        SQ_RPUL: begin
          if (wcnt_q == LAST) begin
            rdata   <= mem_rdata;
            state_q <= SQ_IDLE;
          end else begin
            wcnt_q <= wcnt_q + CW'(1);
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign ce_n    = (state_q == SQ_IDLE);
  assign we_n    = (state_q != SQ_WPUL);
  assign oe_n    = (state_q != SQ_RPUL);
  assign wr_done = (state_q == SQ_WHLD);

  // R3 / R4: host pacing contract, no new strobe while a cycle runs
  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != SQ_IDLE) |-> !(wr_go || rd_go));
endmodule

// File: rtl/byte_stream_bridge.sv
module byte_stream_bridge #(
  parameter int ADDR_W   = 23,
  parameter int DATA_W   = 8,
  parameter int WAIT_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_phase,
  input  logic              hst_wr_n,
  input  logic              hst_rd_n,
  input  logic [DATA_W-1:0] hst_data_in,
  output logic [DATA_W-1:0] hst_data_out,
  output logic              hst_data_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n
);
  logic addr_load, data_wr, rd_start, rd_done;
  logic wr_done, step, dir;

  bsb_host_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (hst_phase),
    .wr_n     (hst_wr_n),
    .rd_n     (hst_rd_n),
    .addr_load(addr_load),
    .data_wr  (data_wr),
    .rd_start (rd_start),
    .rd_done  (rd_done)
  );

  assign step = wr_done || rd_done;

  bsb_addr_counter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (addr_load),
    .load_byte(hst_data_in),
    .step     (step),
    .addr     (mem_addr),
    .dir      (dir)
  );

  bsb_mem_seq #(.DATA_W(DATA_W), .WAIT_CYC(WAIT_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_go    (data_wr),
    .wr_byte  (hst_data_in),
    .rd_go    (rd_start),
    .mem_rdata(mem_rdata),
    .ce_n     (mem_ce_n),
    .oe_n     (mem_oe_n),
    .we_n     (mem_we_n),
    .wdata    (mem_wdata),
    .rdata    (hst_data_out),
    .wr_done  (wr_done)
  );

  assign hst_data_oe = !hst_rd_n && !hst_phase;

  // Checker: length of the current write-enable pulse
  logic [15:0] we_lo_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)         we_lo_cnt <= '0;
    else if (!mem_we_n) we_lo_cnt <= we_lo_cnt + 16'd1;
    else                we_lo_cnt <= '0;
  end

  assert_we_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_cnt == 16'(WAIT_CYC)));

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_wdata)));

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |-> (!mem_ce_n && (mem_we_n || mem_oe_n)));

  assert_addr_phase_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hst_rd_n && hst_phase) |-> mem_oe_n);
endmodule

// File: tb/byte_stream_bridge_bench.sv
module byte_stream_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_CYC   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hst_phase = 1'b0;
  logic hst_wr_n = 1'b1;
  logic hst_rd_n = 1'b1;
  logic [7:0] hst_data_in = 8'h00;
  logic [7:0] hst_data_out;
  logic hst_data_oe;
  logic [22:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata;
  logic mem_ce_n, mem_oe_n, mem_we_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_stream_bridge #(.WAIT_CYC(WAIT_CYC)) u_byte_stream_bridge (
    .clk(clk), .rst_n(rst_n), .hst_phase(hst_phase), .hst_wr_n(hst_wr_n),
    .hst_rd_n(hst_rd_n), .hst_data_in(hst_data_in), .hst_data_out(hst_data_out),
    .hst_data_oe(hst_data_oe), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n)
  );

  // Memory device model
  logic [7:0] dev_mem [int];
  function automatic logic [7:0] dev_read(input logic [22:0] a);
    return dev_mem.exists(int'(a)) ? dev_mem[int'(a)] : 8'h00;
  endfunction
  assign mem_rdata = !mem_oe_n ? dev_read(mem_addr) : 8'h00;
  always @(posedge clk) if (!mem_ce_n && !mem_we_n) dev_mem[int'(mem_addr)] = mem_wdata;

  int compared = 0, mismatched = 0, r10_viol = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model
  logic [23:0] exp_cnt = 24'h0;
  logic [7:0]  ref_mem [int];
  logic [7:0]  exp_rq[$];
  logic [22:0] exp_wa[$];
  logic [7:0]  exp_wd[$];

  function automatic void model_step();
    if (exp_cnt[23]) exp_cnt[22:0] = exp_cnt[22:0] - 23'd1;
    else             exp_cnt[22:0] = exp_cnt[22:0] + 23'd1;
  endfunction

  task automatic wr_strobe(input logic ph, input logic [7:0] b);
    @(negedge clk);
    hst_phase = ph; hst_data_in = b; hst_wr_n = 1'b0;
    repeat (2) @(negedge clk);
    hst_wr_n = 1'b1;
    repeat (WAIT_CYC + 4) @(negedge clk);
  endtask

  task automatic load_addr(input logic [23:0] v);
    wr_strobe(1'b1, v[23:16]);
    wr_strobe(1'b1, v[15:8]);
    wr_strobe(1'b1, v[7:0]);
    exp_cnt = v;
    check(mem_addr == v[22:0], "R2 load", 32'(mem_addr), 32'(v[22:0]));
  endtask

  task automatic data_wr(input logic [7:0] b);
    exp_wa.push_back(exp_cnt[22:0]);
    exp_wd.push_back(b);
    ref_mem[int'(exp_cnt[22:0])] = b;
    model_step();
    wr_strobe(1'b0, b);
  endtask

  task automatic data_rd();
    exp_rq.push_back(ref_mem.exists(int'(exp_cnt[22:0])) ? ref_mem[int'(exp_cnt[22:0])] : 8'h00);
    @(negedge clk);
    hst_phase = 1'b0; hst_rd_n = 1'b0;
    repeat (WAIT_CYC + 3) @(negedge clk);
    check(hst_data_oe == 1'b1, "R8 drive in read", 32'(hst_data_oe), 32'd1);
    hst_rd_n = 1'b1;
    model_step();
    repeat (2) @(negedge clk);
    check(hst_data_oe == 1'b0, "R8 release", 32'(hst_data_oe), 32'd0);
  endtask

  // Monitors
  always @(posedge hst_rd_n) begin
    if (!hst_phase && exp_rq.size() > 0) begin
      logic [7:0] e;
      e = exp_rq.pop_front();
      check(hst_data_out == e, "R4 read data", 32'(hst_data_out), 32'(e));
    end
  end

  always @(negedge mem_we_n) begin
    if (exp_wa.size() > 0) begin
      logic [22:0] ea;
      logic [7:0]  ed;
      ea = exp_wa.pop_front();
      ed = exp_wd.pop_front();
      check(mem_addr == ea, "R3 write address", 32'(mem_addr), 32'(ea));
      check(mem_wdata == ed, "R3 write data", 32'(mem_wdata), 32'(ed));
    end
  end

  always @(negedge clk) begin
    if (rst_n && (((!mem_we_n || !mem_oe_n) && mem_ce_n) || (!mem_we_n && !mem_oe_n)))
      r10_viol++;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    check(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes idle", {mem_ce_n, mem_we_n, mem_oe_n}, 32'h7);
    check(hst_data_oe == 1'b0, "R1 bus released", 32'(hst_data_oe), 32'd0);
    check(mem_addr == 23'd0, "R1 address zero", 32'(mem_addr), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_ce_n == 1'b1 && mem_addr == 23'd0, "R1 after reset", 32'(mem_addr), 32'd0);

    // R5: upward stream
    load_addr(24'h000100);
    data_wr(8'hA5); data_wr(8'h5A); data_wr(8'h3C); data_wr(8'hC3);
    check(mem_addr == 23'h104, "R5 after writes", 32'(mem_addr), 32'h104);
    load_addr(24'h000100);
    for (int i = 0; i < 4; i++) data_rd();
    check(mem_addr == 23'h104, "R5 after reads", 32'(mem_addr), 32'h104);

    // R6: downward stream
    load_addr(24'h800200);
    data_wr(8'h11); data_wr(8'h22); data_wr(8'h33);
    check(mem_addr == 23'h1FD, "R6 after writes", 32'(mem_addr), 32'h1FD);
    load_addr(24'h0001FE);
    for (int i = 0; i < 3; i++) data_rd();

    // R7: wrap both ways
    load_addr(24'h7FFFFF);
    data_wr(8'h77); data_wr(8'h88);
    check(mem_addr == 23'd1, "R7 wrap up", 32'(mem_addr), 32'd1);
    load_addr(24'h800000);
    data_rd(); data_rd();
    check(mem_addr == 23'h7FFFFE, "R7 wrap down", 32'(mem_addr), 32'h7FFFFE);

    // R9: read strobe in address phase is ignored
    load_addr(24'h000100);
    @(negedge clk);
    hst_phase = 1'b1; hst_rd_n = 1'b0;
    repeat (WAIT_CYC + 3) @(negedge clk);
    check(mem_oe_n == 1'b1 && mem_ce_n == 1'b1, "R9 no memory cycle", {mem_ce_n, mem_oe_n}, 32'h3);
    check(hst_data_oe == 1'b0, "R8 no drive in address phase", 32'(hst_data_oe), 32'd0);
    hst_rd_n = 1'b1;
    repeat (2) @(negedge clk);
    check(mem_addr == 23'h100, "R9 counter unchanged", 32'(mem_addr), 32'h100);
    data_rd();

    check(r10_viol == 0, "R10 strobe exclusivity", 32'(r10_viol), 32'd0);
    check(exp_rq.size() == 0 && exp_wa.size() == 0, "R3 R4 all transfers seen",
          32'(exp_rq.size() + exp_wa.size()), 32'd0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule